// File: doc/BRIEF.md
# Instruction operand value classifier

This block sorts the operand values of one retired instruction into corner-case classes. On each beat where `in_valid` is high it takes the values of source register 1, source register 2 and the destination, together with the immediate, the immediate's bit length, a format tag, a class tag and a divide flag. It registers a set of small category codes:

- a sign bit for each operand;
- a special-value code for each operand (zero, most negative, most positive, or none of these);
- a divide-result code;
- an unsigned compare result;
- a bitwise-similarity code.

It does not compute arithmetic results. It labels the operand pairs that tend to expose bugs, such as signed divide overflow, division by zero and bit patterns that differ in only a few places. These labels can be used, for example, to count how often a test stream reaches such cases.

All outputs come from registers loaded on a valid beat, so the results appear one cycle after the inputs. Several codes are only meaningful for some instructions. These codes keep their last value on any beat that does not concern them.

Top module: `opclass_top`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. With `in_valid` low, no code output changes.
- R2: On a valid beat, each of `rs1_neg`, `rs2_neg` and `rd_neg` takes the most significant bit of its operand. `imm_neg` takes bit 31 of the immediate.
- R3: The operand special-value code is checked in this order: 3 when the value is 0, 1 when only the MSB is set, 2 when every bit except the MSB is set, 0 otherwise. Fields are packed as {rs1, rs2, rd} in `op_sv[5:0]`, 2 bits each, with rs1 in the top field.
- R4: For format 3 (upper immediate), the immediate code is 3 when the immediate is 0, 2 when it equals (1 << `imm_len`) - 1, and 0 otherwise.
- R5: For formats 2 and 4..7, the immediate code is 3 for zero, 1 when the immediate equals -2^(`imm_len`-1), 2 when it equals 2^(`imm_len`-1)-1, and 0 otherwise. The comparisons are made on the 32-bit immediate taken as signed. `imm_len` ranges from 1 to 32.
- R6: For format 0 (register-register) and format 1 (compressed register-register), `imm_sv` keeps its previous value.
- R7: When `is_div` is high, `div_code` becomes 1 if the divisor (source register 2) is 0. It becomes 2 if the divisor is all ones and the dividend (source register 1) has only its MSB set. It becomes 0 otherwise.
- R8: When `is_div` is low, `div_code` keeps its previous value.
- R9: For class 1 (compare or branch), `cmp_code` becomes 0 when the operands are equal, 1 when source 1 is larger and 2 when it is smaller, compared unsigned. The second operand is the zero-extended immediate for format 2 and source register 2 for every other format.
- R10: For class 2 (logical), `sim_code` uses the same second operand as R9. It becomes 0 when the operands are equal, 1 when all `DATA_W` bits differ, 2 when fewer than `NEAR_LIMIT` (5) bits differ, and 3 otherwise.
- R11: `cmp_code` keeps its value unless the class is 1, and `sim_code` keeps its value unless the class is 2.
- R12: A synchronous active-low reset clears `out_valid`, every sign bit and every code to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand beat present |
| rs1_val | input | DATA_W | Source register 1 value (dividend) |
| rs2_val | input | DATA_W | Source register 2 value (divisor) |
| rd_val | input | DATA_W | Destination value |
| imm_val | input | 32 | Immediate value |
| imm_len | input | 6 | Immediate bit length, 1..32 |
| fmt | input | 3 | Format tag: 0 reg-reg, 1 compressed reg-reg, 2 immediate, 3 upper immediate, others other |
| cls | input | 2 | Class tag: 1 compare/branch, 2 logical, others other |
| is_div | input | 1 | Divide or remainder instruction |
| out_valid | output | 1 | Registered codes refreshed by the previous beat |
| rs1_neg | output | 1 | Sign of source register 1 |
| rs2_neg | output | 1 | Sign of source register 2 |
| rd_neg | output | 1 | Sign of destination |
| imm_neg | output | 1 | Sign of immediate |
| op_sv | output | 6 | Special-value codes {rs1, rs2, rd} |
| imm_sv | output | 2 | Immediate special-value code |
| div_code | output | 2 | 0 normal, 1 divide by zero, 2 overflow |
| cmp_code | output | 2 | 0 equal, 1 larger, 2 smaller |
| sim_code | output | 2 | 0 identical, 1 opposite, 2 similar, 3 different |

## Verification
The assertions check on every cycle the one-cycle valid latency and the hold rules. A code may change only on a beat of its own class, format or divide flag. They also check that the sign bits follow the operand MSBs and that a zero divisor always produces the divide-by-zero code. Only the bench's scenarios show that the codes have the right values. These scenarios cover the ordered special-value checks, signed against unsigned immediate limits at lengths 12, 16, 20 and 32, the unsigned compare on a value that is negative when taken as signed, and the population-count boundary between the similar and different codes.

// File: rtl/opclass_pkg.sv
`timescale 1ns/1ps
// opclass_pkg: code encodings and tag values shared by the classifier.
// Assumes: all codes fit in 2 bits; tag values are fixed by the port spec.
package opclass_pkg;

    typedef enum logic [1:0] {
        SV_NORMAL = 2'd0,
        SV_MIN    = 2'd1,
        SV_MAX    = 2'd2,
        SV_ZERO   = 2'd3
    } sv_code_t;

    typedef enum logic [1:0] {
        DV_NORMAL = 2'd0,
        DV_BYZERO = 2'd1,
        DV_OVF    = 2'd2,
        DV_RSVD   = 2'd3
    } div_code_t;

    typedef enum logic [1:0] {
        CM_EQUAL   = 2'd0,
        CM_LARGER  = 2'd1,
        CM_SMALLER = 2'd2,
        CM_RSVD    = 2'd3
    } cmp_code_t;

    typedef enum logic [1:0] {
        SM_IDENT = 2'd0,
        SM_OPPO  = 2'd1,
        SM_NEAR  = 2'd2,
        SM_DIFF  = 2'd3
    } sim_code_t;

    localparam logic [2:0] FMT_REG   = 3'd0;
    localparam logic [2:0] FMT_CREG  = 3'd1;
    localparam logic [2:0] FMT_IMM   = 3'd2;
    localparam logic [2:0] FMT_UPPER = 3'd3;

    localparam logic [1:0] CLS_CMP   = 2'd1;
    localparam logic [1:0] CLS_LOGIC = 2'd2;

    localparam int IMM_W    = 32;
    localparam int IMMLEN_W = 6;

endpackage

// File: rtl/opclass_special_val.sv
`timescale 1ns/1ps
// opclass_special_val: combinational special-value code for one operand.
// Checks zero first, then "only MSB set", then "all but MSB set".
// Assumes: W >= 2.
module opclass_special_val
    import opclass_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    output sv_code_t     code
);

    localparam logic [W-1:0] MIN_PAT = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_PAT = {1'b0, {(W-1){1'b1}}};

    // Ordered priority decode of the operand pattern.
    always_comb begin
        if (value == '0)           code = SV_ZERO;
        else if (value == MIN_PAT) code = SV_MIN;
        else if (value == MAX_PAT) code = SV_MAX;
        else                       code = SV_NORMAL;
    end

endmodule

// File: rtl/opclass_imm_class.sv
`timescale 1ns/1ps
// opclass_imm_class: special-value code for the immediate, length aware.
// Upper-immediate formats use an unsigned limit; all others use signed limits.
// Assumes: len is 1..IMM_W; zero is always checked first.
module opclass_imm_class
    import opclass_pkg::*;
(
    input  logic [IMM_W-1:0]    imm,
    input  logic [IMMLEN_W-1:0] len,
    input  logic                is_upper,
    output sv_code_t            code
);

    logic [IMM_W:0]   umax_wide;
    logic [IMM_W-1:0] umax;
    logic [IMM_W-1:0] smax;
    logic [IMM_W-1:0] smin;

    // Length-derived limits; the signed minimum is the complement of the maximum.
    always_comb begin
        umax_wide = ({{IMM_W{1'b0}}, 1'b1} << len) - {{IMM_W{1'b0}}, 1'b1};
        umax      = umax_wide[IMM_W-1:0];
        smax      = ({{(IMM_W-1){1'b0}}, 1'b1} << (len - {{(IMMLEN_W-1){1'b0}}, 1'b1}))
                    - {{(IMM_W-1){1'b0}}, 1'b1};
        smin      = ~smax;
    end

    // Ordered decode, selecting the limit set by format.
    always_comb begin
        code = SV_NORMAL;
        if (imm == '0) begin
            code = SV_ZERO;
        end else if (is_upper) begin
            if (imm == umax) code = SV_MAX;
        end else begin
            if (imm == smin)      code = SV_MIN;
            else if (imm == smax) code = SV_MAX;
        end
    end

endmodule

// File: rtl/opclass_popcount.sv
`timescale 1ns/1ps
// opclass_popcount: combinational population count as a balanced adder tree.
// Heap-indexed nodes: leaves at N..2N-1 (zero padded), root at node 1.
// Assumes: W >= 1; tree depth is clog2(W) adders.
module opclass_popcount #(
    parameter int W     = 32,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     bits,
    output logic [CNT_W-1:0] count
);

    localparam int LVL = (W > 1) ? $clog2(W) : 0;
    localparam int N   = 1 << LVL;

    logic [CNT_W-1:0] node [1:2*N-1];

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_leaf
            if (i < W) begin : g_bit
                assign node[N+i] = {{(CNT_W-1){1'b0}}, bits[i]};
            end else begin : g_pad
                assign node[N+i] = '0;
            end
        end
        for (i = 1; i < N; i++) begin : g_sum
            assign node[i] = node[2*i] + node[2*i+1];
        end
    endgenerate

    assign count = node[1];

endmodule

// File: rtl/opclass_pair_class.sv
`timescale 1ns/1ps
// opclass_pair_class: combinational pair classes.
// Computes the unsigned compare of (a, b), the bit similarity of (a, b) and the
// divide class of (dividend, divisor).
// Assumes: the caller selects b (immediate or source 2) before this block.
module opclass_pair_class
    import opclass_pkg::*;
#(
    parameter int W          = 32,
    parameter int NEAR_LIMIT = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output cmp_code_t    cmp,
    output sim_code_t    sim,
    output div_code_t    dv
);

    localparam int CNT_W = $clog2(W + 1);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [CNT_W-1:0] diff_cnt;

    opclass_popcount #(.W(W), .CNT_W(CNT_W)) i_popcount (
        .bits  (a ^ b),
        .count (diff_cnt)
    );

    // Unsigned three-way compare.
    always_comb begin
        if (a == b)     cmp = CM_EQUAL;
        else if (a < b) cmp = CM_SMALLER;
        else            cmp = CM_LARGER;
    end

    // Similarity class from the count of differing bits.
    always_comb begin
        if (a == b)                           sim = SM_IDENT;
        else if (diff_cnt == CNT_W'(W))       sim = SM_OPPO;
        else if (diff_cnt < CNT_W'(NEAR_LIMIT)) sim = SM_NEAR;
        else                                  sim = SM_DIFF;
    end

    // Divide corner cases: zero divisor, then signed overflow.
    always_comb begin
        if (divisor == '0)                              dv = DV_BYZERO;
        else if (divisor == '1 && dividend == MOST_NEG) dv = DV_OVF;
        else                                            dv = DV_NORMAL;
    end

endmodule

// File: rtl/opclass_top.sv
`timescale 1ns/1ps
// opclass_top: registered operand value classifier, one-cycle latency.
// Every output is a register loaded on in_valid. The compare, similarity,
// divide and immediate codes load only on beats that concern them.
// Assumes: synchronous active-low reset; imm_len in 1..32.
module opclass_top
    import opclass_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NEAR_LIMIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] rs1_val,
    input  logic [DATA_W-1:0] rs2_val,
    input  logic [DATA_W-1:0] rd_val,
    input  logic [31:0]       imm_val,
    input  logic [5:0]        imm_len,
    input  logic [2:0]        fmt,
    input  logic [1:0]        cls,
    input  logic              is_div,
    output logic              out_valid,
    output logic              rs1_neg,
    output logic              rs2_neg,
    output logic              rd_neg,
    output logic              imm_neg,
    output logic [5:0]        op_sv,
    output logic [1:0]        imm_sv,
    output logic [1:0]        div_code,
    output logic [1:0]        cmp_code,
    output logic [1:0]        sim_code
);

    localparam int NOPS = 3;

    logic [DATA_W-1:0] ops [NOPS];
    sv_code_t          op_code [NOPS];
    sv_code_t          imm_code;
    cmp_code_t         cmp_nxt;
    sim_code_t         sim_nxt;
    div_code_t         div_nxt;
    logic [DATA_W-1:0] opnd_b;
    logic              imm_fmt_reg;

    assign ops[0] = rs1_val;
    assign ops[1] = rs2_val;
    assign ops[2] = rd_val;

    genvar k;
    generate
        for (k = 0; k < NOPS; k++) begin : g_opsv
            opclass_special_val #(.W(DATA_W)) i_sv (
                .value (ops[k]),
                .code  (op_code[k])
            );
        end
    endgenerate

    opclass_imm_class i_imm (
        .imm      (imm_val),
        .len      (imm_len),
        .is_upper (fmt == FMT_UPPER),
        .code     (imm_code)
    );

    // Second operand: immediate for immediate format, else source 2.
    assign opnd_b      = (fmt == FMT_IMM) ? DATA_W'(imm_val) : rs2_val;
    assign imm_fmt_reg = (fmt == FMT_REG) || (fmt == FMT_CREG);

    opclass_pair_class #(.W(DATA_W), .NEAR_LIMIT(NEAR_LIMIT)) i_pair (
        .a        (rs1_val),
        .b        (opnd_b),
        .dividend (rs1_val),
        .divisor  (rs2_val),
        .cmp      (cmp_nxt),
        .sim      (sim_nxt),
        .dv       (div_nxt)
    );

    // Valid pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Signs and operand codes, loaded on every valid beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {rs1_neg, rs2_neg, rd_neg, imm_neg} <= '0;
            op_sv <= '0;
        end else if (in_valid) begin
            rs1_neg <= rs1_val[DATA_W-1];
            rs2_neg <= rs2_val[DATA_W-1];
            rd_neg  <= rd_val[DATA_W-1];
            imm_neg <= imm_val[31];
            op_sv   <= {op_code[0], op_code[1], op_code[2]};
        end
    end

    // Immediate code, skipped for register-register formats.
    always_ff @(posedge clk) begin
        if (!rst_n)                         imm_sv <= '0;
        else if (in_valid && !imm_fmt_reg)  imm_sv <= imm_code;
    end

    // Divide code, loaded only for divide instructions.
    always_ff @(posedge clk) begin
        if (!rst_n)                   div_code <= '0;
        else if (in_valid && is_div)  div_code <= div_nxt;
    end

    // Compare and similarity codes, each gated by its class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_code <= '0;
            sim_code <= '0;
        end else if (in_valid) begin
            if (cls == CLS_CMP)   cmp_code <= cmp_nxt;
            if (cls == CLS_LOGIC) sim_code <= sim_nxt;
        end
    end

    // ---------------- assertions ----------------
    p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(op_sv) && $stable(cmp_code) && $stable(sim_code)));
    p_sign_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (rs1_neg == $past(rs1_val[DATA_W-1]) && imm_neg == $past(imm_val[31])));
    p_imm_reg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_REG || fmt == FMT_CREG) |=> $stable(imm_sv));
    p_div_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_div && rs2_val == '0) |=> (div_code == 2'd1));
    p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && is_div) |=> $stable(div_code));
    p_cmp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && cls == CLS_CMP) |=> $stable(cmp_code));
    p_sim_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && cls == CLS_LOGIC) |=> $stable(sim_code));
    p_sim_ident_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == CLS_LOGIC && fmt != FMT_IMM && rs1_val == rs2_val)
        |=> (sim_code == 2'd0));

endmodule

// File: tb/test_opclass_top.sv
`timescale 1ns/1ps
// test_opclass_top: table-driven bench followed by directed reset/corner tests.
module test_opclass_top;

    typedef struct packed {
        logic [31:0] rs1;
        logic [31:0] rs2;
        logic [31:0] rd;
        logic [31:0] imm;
        logic [5:0]  len;
        logic [2:0]  fmt;
        logic [1:0]  cls;
        logic        dv;
        logic [3:0]  e_sign;   // {rs1, rs2, rd, imm}
        logic [7:0]  e_sv;     // {rs1, rs2, rd, imm}
        logic [1:0]  e_div;
        logic [1:0]  e_cmp;
        logic [1:0]  e_sim;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h0, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 6'd12, 3'd2, 2'd1, 1'b1,
          4'b0100, 8'hDB, 2'd0, 2'd0, 2'd0},
        '{32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h800, 6'd12, 3'd2, 2'd0, 1'b1,
          4'b1100, 8'h40, 2'd2, 2'd0, 2'd0},
        '{32'h5, 32'h0, 32'h0, 32'h7FF, 6'd12, 3'd2, 2'd1, 1'b1,
          4'b0000, 8'h3E, 2'd1, 2'd2, 2'd0},
        '{32'h0000_FFFF, 32'h0000_FFF0, 32'hFFFF_FFFF, 32'hFFFF_F800, 6'd12, 3'd0, 2'd2, 1'b0,
          4'b0011, 8'h02, 2'd1, 2'd2, 2'd2},
        '{32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h1, 32'hFFFF_F800, 6'd12, 3'd4, 2'd2, 1'b0,
          4'b0101, 8'h01, 2'd1, 2'd2, 2'd1},
        '{32'h1F, 32'h0, 32'h7FFF_FFFF, 32'h000F_FFFF, 6'd20, 3'd3, 2'd2, 1'b0,
          4'b0000, 8'h3A, 2'd1, 2'd2, 2'd3},
        '{32'hFFFF_FFFF, 32'h1, 32'h8000_0000, 32'h7FF, 6'd12, 3'd1, 2'd1, 1'b1,
          4'b1010, 8'h06, 2'd0, 2'd1, 2'd3},
        '{32'h1234, 32'h1234, 32'h0, 32'h1234, 6'd16, 3'd2, 2'd2, 1'b0,
          4'b0000, 8'h0C, 2'd0, 2'd1, 2'd0},
        '{32'h3, 32'h2, 32'h2, 32'h0, 6'd20, 3'd3, 2'd1, 1'b1,
          4'b0000, 8'h03, 2'd0, 2'd1, 2'd0},
        '{32'h1, 32'hFFFF_FFFF, 32'h5, 32'h7_FFFF, 6'd20, 3'd3, 2'd0, 1'b0,
          4'b0100, 8'h00, 2'd0, 2'd1, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] rs1_val = '0, rs2_val = '0, rd_val = '0, imm_val = '0;
    logic [5:0]  imm_len = 6'd12;
    logic [2:0]  fmt = '0;
    logic [1:0]  cls = '0;
    logic        is_div = 1'b0;
    logic        out_valid, rs1_neg, rs2_neg, rd_neg, imm_neg;
    logic [5:0]  op_sv;
    logic [1:0]  imm_sv, div_code, cmp_code, sim_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    opclass_top i_opclass_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .rd_val(rd_val),
        .imm_val(imm_val), .imm_len(imm_len), .fmt(fmt), .cls(cls), .is_div(is_div),
        .out_valid(out_valid), .rs1_neg(rs1_neg), .rs2_neg(rs2_neg), .rd_neg(rd_neg),
        .imm_neg(imm_neg), .op_sv(op_sv), .imm_sv(imm_sv), .div_code(div_code),
        .cmp_code(cmp_code), .sim_code(sim_code)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        rs1_val = v.rs1; rs2_val = v.rs2; rd_val = v.rd; imm_val = v.imm;
        imm_len = v.len; fmt = v.fmt; cls = v.cls; is_div = v.dv; in_valid = vld;
    endtask

    task automatic chk_all(input string tag, input logic [3:0] s, input logic [7:0] sv,
                           input logic [1:0] d, input logic [1:0] c, input logic [1:0] m);
        chk({tag, " signs R2"}, {4'b0, rs1_neg, rs2_neg, rd_neg, imm_neg}, {4'b0, s});
        chk({tag, " operand codes R3"}, {2'b0, op_sv}, {2'b0, sv[7:2]});
        chk({tag, " imm code R4/R5/R6"}, {6'b0, imm_sv}, {6'b0, sv[1:0]});
        chk({tag, " div code R7/R8"}, {6'b0, div_code}, {6'b0, d});
        chk({tag, " cmp code R9/R11"}, {6'b0, cmp_code}, {6'b0, c});
        chk({tag, " sim code R10/R11"}, {6'b0, sim_code}, {6'b0, m});
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        vec_t t;
        repeat (3) @(negedge clk);
        // R12: reset state.
        chk("reset valid R12", {7'b0, out_valid}, 8'h0);
        chk_all("reset R12", 4'b0, 8'h00, 2'd0, 2'd0, 2'd0);
        rst_n = 1'b1;

        // Table walk, back-to-back valid beats; R1 latency checked each beat.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i], 1'b1);
            @(negedge clk);
            chk($sformatf("vec%0d valid R1", i), {7'b0, out_valid}, 8'h1);
            chk_all($sformatf("vec%0d", i), VECS[i].e_sign, VECS[i].e_sv,
                    VECS[i].e_div, VECS[i].e_cmp, VECS[i].e_sim);
        end

        // R1: inputs change with valid low; nothing moves, valid drops.
        t = VECS[0];
        t.cls = 2'd2; t.dv = 1'b1; t.fmt = 3'd4;
        drive(t, 1'b0);
        @(negedge clk);
        chk("idle valid R1", {7'b0, out_valid}, 8'h0);
        @(negedge clk);
        chk_all("idle hold R1", 4'b0100, 8'h00, 2'd0, 2'd1, 2'd0);

        // R4: 32-bit upper immediate of all ones is the maximum.
        t = '0;
        t.imm = 32'hFFFF_FFFF; t.len = 6'd32; t.fmt = 3'd3;
        drive(t, 1'b1);
        @(negedge clk);
        chk("upper len32 R4", {6'b0, imm_sv}, 8'd2);
        chk("imm sign bit31 R2", {7'b0, imm_neg}, 8'h1);

        // R5: signed 32-bit minimum.
        t.imm = 32'h8000_0000; t.fmt = 3'd2;
        drive(t, 1'b1);
        @(negedge clk);
        chk("signed len32 min R5", {6'b0, imm_sv}, 8'd1);
        chk("zero operands R3", {2'b0, op_sv}, 8'h3F);

        // R12: mid-run reset clears everything.
        t = VECS[1];
        drive(t, 1'b1);
        @(negedge clk);
        chk("pre-reset div R7", {6'b0, div_code}, 8'd2);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        chk("mid reset valid R12", {7'b0, out_valid}, 8'h0);
        chk_all("mid reset R12", 4'b0, 8'h00, 2'd0, 2'd0, 2'd0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule